// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement and Self-Refresh Sequencing

This block decides when a DDR SDRAM controller must send auto-refresh commands. A free-running interval timer adds one owed refresh per average refresh period. The command arbiter may postpone owed refreshes while it serves traffic, or pull refreshes in early while it is idle. The scheduler bounds both directions at a fixed depth. It also raises a separate urgent flag as the hard ceiling on the gap between two refreshes approaches. It never issues commands itself. It offers a request, an urgent flag and a permission signal, and it learns about each refresh through a one-cycle issue pulse from the arbiter.

The same block gates the clock-enable pin for self-refresh. Entry is granted only when no refresh is owed, the bank-idle precharge time has passed and no refresh recovery window is open. After exit it holds off non-read commands and read commands for two separate counts. Every time limit is given in picoseconds and turned into clock cycles by rounding up against a clock-period parameter. A density parameter selects the average interval and the hard ceiling.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it, cke, cmd_ready and rd_ready are 1 and rf_req, rf_urgent and rf_allow are 0.
- R2: The average period is REFI_CYC = ceil(7.8 us / clock), or ceil(15.625 us / clock) when DENSITY_512 is 0. With no refresh issued, rf_req goes high exactly REFI_CYC clock edges after reset is released.
- R3: Each elapsed period adds one owed refresh and each accepted issue removes one. rf_req is high while at least one refresh is owed, and it drops after the issue that clears the last one.
- R4: Owed refreshes saturate at MAX_DEBT (8). When the count reaches the cap, rf_urgent rises in the same cycle. Periods that end while at the cap add nothing, so MAX_DEBT issues clear the debt completely.
- R5: The ceiling is GAP_CYC = ceil(70.3 us / clock), or ceil(140.6 us / clock) for the smaller density. rf_urgent rises once GAP_CYC - URGENT_LEAD edges have passed since the last accepted refresh, even when no refresh is owed.
- R6: At most MAX_DEBT refreshes may be issued ahead of schedule. At that point rf_allow is 0, and an rf_issue pulse is ignored: cmd_ready stays 1.
- R7: rf_allow needs banks_idle to have been high for TRP_CYC = ceil(TRP_PS / clock) consecutive edges. One low cycle restarts that count.
- R8: An rf_issue pulse is accepted when rf_allow is 1. After that edge, cmd_ready and rd_ready are 0 for exactly TRFC_CYC cycles, and cke stays 1 throughout.
- R9: Self-refresh starts when sr_req is 1, no refresh is owed, the R7 condition holds and no R8 window is open. cke falls at the next edge, and while cke is 0, cmd_ready, rd_ready and rf_allow are 0.
- R10: When sr_req drops during self-refresh, cke rises at the next edge. cmd_ready returns XSNR_CYC = ceil(TXSNR_PS / clock) edges later, and rd_ready returns TXSRD_CYC (200) edges later.
- R11: During self-refresh the period and gap timers hold and the debt is cleared. When rd_ready returns after exit, both timers restart from zero, so rf_req next rises REFI_CYC edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks are precharged this cycle |
| rf_issue | input | 1 | Arbiter sends an auto-refresh this cycle |
| sr_req | input | 1 | Level request to stay in self-refresh |
| rf_req | output | 1 | A refresh is owed or the ceiling is near |
| rf_urgent | output | 1 | Refresh must beat all other traffic |
| rf_allow | output | 1 | An auto-refresh may be issued now |
| cke | output | 1 | Clock-enable level for the memory |
| cmd_ready | output | 1 | Non-read commands may be issued |
| rd_ready | output | 1 | Read commands may be issued |

## Verification
The bound checker watches several rules on every cycle. It checks that cke stays high during refresh recovery, that an accepted issue closes both ready outputs on the next cycle, and that nothing is ready or allowed while cke is low. It also checks that reads stay blocked on the cycle cke returns and that the debt never leaves its signed range. The exact cycle counts can only be shown by the bench's scenarios: the period, the cap on owed refreshes, the gap ceiling, the pull-in limit, the precharge wait and the two exit delays. The same holds for the timers restarting after exit.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_SELF = 2'd1,
    PS_WAKE = 2'd2
  } pwr_state_t;

  // Picoseconds to whole clock cycles, rounded up.
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int REFI_CYC = 1300,
  parameter int GAP_CYC  = 11717,
  parameter int LEAD     = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick,
  output logic gap_near
);
  localparam int RW = $clog2(REFI_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [RW-1:0] REFI_LAST = RW'(REFI_CYC - 1);
  localparam logic [GW-1:0] GAP_TOP   = GW'(GAP_CYC);
  localparam logic [GW-1:0] GAP_WARN  = GW'(GAP_CYC - LEAD);

  logic [RW-1:0] refi_q, refi_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    tick = run && (refi_q == REFI_LAST);
    if (!run || tick) refi_d = '0;
    else              refi_d = refi_q + 1'b1;

    if (!run || restart)      gap_d = '0;
    else if (gap_q == GAP_TOP) gap_d = gap_q;
    else                      gap_d = gap_q + 1'b1;
  end

  assign gap_near = run && (gap_q >= GAP_WARN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refi_q <= '0;
      gap_q  <= '0;
    end else begin
      refi_q <= refi_d;
      gap_q  <= gap_d;
    end
  end
endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 add,
  input  logic                 sub,
  output logic                 owed,
  output logic                 at_cap,
  output logic                 pull_ok,
  output logic                 none_owed,
  output logic signed [DW-1:0] debt
);
  localparam logic signed [DW-1:0] D_MAX = DW'(MAX_DEBT);
  localparam logic signed [DW-1:0] D_MIN = -D_MAX;
  localparam logic signed [DW-1:0] D_ONE = DW'(1);

  logic signed [DW-1:0] debt_q, debt_d;
  logic add_eff;

  always_comb begin
    add_eff = add && (debt_q != D_MAX);
    debt_d  = debt_q;
    if (!run)                debt_d = '0;
    else if (add_eff && !sub) debt_d = debt_q + D_ONE;
    else if (!add_eff && sub) debt_d = debt_q - D_ONE;
  end

  assign owed      = debt_q > 0;
  assign none_owed = !owed;
  assign at_cap    = debt_q == D_MAX;
  assign pull_ok   = debt_q > D_MIN;
  assign debt      = debt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end
endmodule

// File: rtl/rfsh_pwr_seq.sv
module rfsh_pwr_seq
  import dram_rfsh_pkg::*;
#(
  parameter int TRFC_CYC = 12,
  parameter int TRP_CYC  = 3,
  parameter int XSNR_CYC = 13,
  parameter int XSRD_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       banks_idle,
  input  logic       issue_ok,
  input  logic       none_owed,
  output pwr_state_t state,
  output logic       rfc_busy,
  output logic       idle_ok,
  output logic       cmd_ready,
  output logic       rd_ready,
  output logic       cke
);
  localparam int FW = $clog2(TRFC_CYC + 1);
  localparam int PW = $clog2(TRP_CYC + 1);
  localparam int XW = $clog2(XSRD_CYC + 1);
  localparam logic [FW-1:0] RFC_LOAD = FW'(TRFC_CYC);
  localparam logic [PW-1:0] RP_TOP   = PW'(TRP_CYC);
  localparam logic [XW-1:0] XS_NR    = XW'(XSNR_CYC);
  localparam logic [XW-1:0] XS_LAST  = XW'(XSRD_CYC - 1);

  pwr_state_t    st_q, st_d;
  logic [FW-1:0] rfc_q, rfc_d;
  logic [PW-1:0] idle_q, idle_d;
  logic [XW-1:0] xs_q, xs_d;
  logic          enter_ok;

  assign rfc_busy = rfc_q != '0;
  assign idle_ok  = idle_q == RP_TOP;
  assign enter_ok = sr_req && none_owed && !rfc_busy && idle_ok && !issue_ok;

  always_comb begin
    if (issue_ok)      rfc_d = RFC_LOAD;
    else if (rfc_busy) rfc_d = rfc_q - 1'b1;
    else               rfc_d = rfc_q;

    if (!banks_idle)       idle_d = '0;
    else if (idle_ok)      idle_d = idle_q;
    else                   idle_d = idle_q + 1'b1;

    xs_d = (st_q == PS_WAKE) ? xs_q + 1'b1 : '0;

    st_d = st_q;
    unique case (st_q)
      PS_RUN:  if (enter_ok) st_d = PS_SELF;
      PS_SELF: if (!sr_req)  st_d = PS_WAKE;
      PS_WAKE: if (xs_q == XS_LAST) st_d = PS_RUN;
      default: st_d = PS_RUN;
    endcase
  end

  assign state     = st_q;
  assign cke       = st_q != PS_SELF;
  assign rd_ready  = (st_q == PS_RUN) && !rfc_busy;
  assign cmd_ready = rd_ready || ((st_q == PS_WAKE) && (xs_q >= XS_NR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_RUN;
      rfc_q  <= '0;
      idle_q <= '0;
      xs_q   <= '0;
    end else begin
      st_q   <= st_d;
      rfc_q  <= rfc_d;
      idle_q <= idle_d;
      xs_q   <= xs_d;
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_PS      = 6000,
  parameter int DENSITY_512 = 1,
  parameter int TRFC_PS     = 72000,
  parameter int TXSNR_PS    = 75000,
  parameter int TRP_PS      = 18000,
  parameter int TXSRD_CYC   = 200,
  parameter int MAX_DEBT    = 8,
  parameter int URGENT_LEAD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic rf_issue,
  input  logic sr_req,
  output logic rf_req,
  output logic rf_urgent,
  output logic rf_allow,
  output logic cke,
  output logic cmd_ready,
  output logic rd_ready
);
  localparam int REFI_PS  = (DENSITY_512 != 0) ? 7800000  : 15625000;
  localparam int GAP_PS   = (DENSITY_512 != 0) ? 70300000 : 140600000;
  localparam int REFI_CYC = cyc_ceil(REFI_PS, CLK_PS);
  localparam int GAP_CYC  = cyc_ceil(GAP_PS, CLK_PS);
  localparam int TRFC_CYC = cyc_ceil(TRFC_PS, CLK_PS);
  localparam int TRP_CYC  = cyc_ceil(TRP_PS, CLK_PS);
  localparam int XSNR_CYC = cyc_ceil(TXSNR_PS, CLK_PS);
  localparam int DEBT_W   = $clog2(MAX_DEBT + 1) + 1;

  pwr_state_t               state;
  logic                     run, tick, gap_near, issue_ok;
  logic                     owed, at_cap, pull_ok, none_owed;
  logic                     rfc_busy, idle_ok;
  logic signed [DEBT_W-1:0] debt_w;

  assign run      = state == PS_RUN;
  assign rf_allow = run && !rfc_busy && idle_ok && pull_ok;
  assign issue_ok = rf_issue && rf_allow;

  rfsh_interval_timer #(
    .REFI_CYC (REFI_CYC),
    .GAP_CYC  (GAP_CYC),
    .LEAD     (URGENT_LEAD)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .restart  (issue_ok),
    .tick     (tick),
    .gap_near (gap_near)
  );

  rfsh_debt_ctr #(
    .MAX_DEBT (MAX_DEBT),
    .DW       (DEBT_W)
  ) u_debt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .add       (tick),
    .sub       (issue_ok),
    .owed      (owed),
    .at_cap    (at_cap),
    .pull_ok   (pull_ok),
    .none_owed (none_owed),
    .debt      (debt_w)
  );

  rfsh_pwr_seq #(
    .TRFC_CYC (TRFC_CYC),
    .TRP_CYC  (TRP_CYC),
    .XSNR_CYC (XSNR_CYC),
    .XSRD_CYC (TXSRD_CYC)
  ) u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_req     (sr_req),
    .banks_idle (banks_idle),
    .issue_ok   (issue_ok),
    .none_owed  (none_owed),
    .state      (state),
    .rfc_busy   (rfc_busy),
    .idle_ok    (idle_ok),
    .cmd_ready  (cmd_ready),
    .rd_ready   (rd_ready),
    .cke        (cke)
  );

  assign rf_urgent = run && (at_cap || gap_near);
  assign rf_req    = run && (owed || gap_near);
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk #(
  parameter int DW       = 5,
  parameter int MAX_DEBT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cmd_ready,
  input logic                 rd_ready,
  input logic                 rf_allow,
  input logic                 issue_ok,
  input logic                 rfc_busy,
  input logic signed [DW-1:0] debt
);
  localparam logic signed [DW-1:0] LIM = DW'(MAX_DEBT);

  // R8
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfc_busy |-> cke);

  // R8
  rfc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> (!cmd_ready && !rd_ready));

  // R9
  sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!rf_allow && !cmd_ready && !rd_ready));

  // R10
  exit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !rd_ready);

  // R4
  debt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debt <= LIM) && (debt >= -LIM));

  // R6
  pull_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |-> (debt > -LIM));
endmodule

bind dram_refresh_sched dram_rfsh_sched_chk #(
  .DW       (DEBT_W),
  .MAX_DEBT (MAX_DEBT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cmd_ready (cmd_ready),
  .rd_ready  (rd_ready),
  .rf_allow  (rf_allow),
  .issue_ok  (issue_ok),
  .rfc_busy  (rfc_busy),
  .debt      (debt_w)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int CLK_PS  = 20000;
  localparam int TRFC_PS = 80000;
  localparam int XSNR_PS = 75000;
  localparam int TRP_PS  = 60000;
  localparam int XSRD    = 200;
  localparam int MAXD    = 8;
  localparam int LEAD    = 32;

  localparam int REFI = (7800000 + CLK_PS - 1) / CLK_PS;
  localparam int GAP  = (70300000 + CLK_PS - 1) / CLK_PS;
  localparam int TRFC = (TRFC_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRP  = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int XSNR = (XSNR_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n, banks_idle, rf_issue, sr_req;
  logic rf_req, rf_urgent, rf_allow, cke, cmd_ready, rd_ready;
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PS(CLK_PS), .DENSITY_512(1), .TRFC_PS(TRFC_PS), .TXSNR_PS(XSNR_PS),
    .TRP_PS(TRP_PS), .TXSRD_CYC(XSRD), .MAX_DEBT(MAXD), .URGENT_LEAD(LEAD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .rf_issue(rf_issue),
    .sr_req(sr_req), .rf_req(rf_req), .rf_urgent(rf_urgent), .rf_allow(rf_allow),
    .cke(cke), .cmd_ready(cmd_ready), .rd_ready(rd_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; banks_idle = 1'b0; rf_issue = 1'b0; sr_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue();
    rf_issue = 1'b1;
    step(1);
    rf_issue = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // Scenario A: reset, precharge wait, period, recovery window, pull-in cap
    do_reset();
    chk("R1 cke", cke, 1);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);
    chk("R1 rf_req", rf_req, 0);
    chk("R1 rf_urgent", rf_urgent, 0);
    chk("R1 rf_allow", rf_allow, 0);
    banks_idle = 1'b1;
    step(TRP - 1);
    chk("R7 allow before tRP", rf_allow, 0);
    step(1);
    chk("R7 allow at tRP", rf_allow, 1);
    banks_idle = 1'b0;
    step(1);
    chk("R7 allow after idle drop", rf_allow, 0);
    banks_idle = 1'b1;
    step(TRP);
    chk("R7 allow after re-idle", rf_allow, 1);
    step(REFI - 1 - (2 * TRP + 1));
    chk("R2 req one edge early", rf_req, 0);
    step(1);
    chk("R2 req at period", rf_req, 1);
    issue();
    chk("R3 req cleared by issue", rf_req, 0);
    for (int k = 0; k <= TRFC; k++) begin
      chk("R8 cmd_ready window", cmd_ready, (k >= TRFC) ? 1 : 0);
      chk("R8 rd_ready window", rd_ready, (k >= TRFC) ? 1 : 0);
      chk("R8 cke held", cke, 1);
      if (k < TRFC) step(1);
    end
    for (int p = 0; p < MAXD; p++) begin
      chk("R6 allow before cap", rf_allow, 1);
      issue();
      step(TRFC);
    end
    chk("R6 allow at pull-in cap", rf_allow, 0);
    issue();
    chk("R6 ignored issue keeps cmd_ready", cmd_ready, 1);

    // Scenario B: postponement up to the cap, saturation
    do_reset();
    step(MAXD * REFI - 1);
    chk("R4 urgent one edge before cap", rf_urgent, 0);
    chk("R3 req while owed", rf_req, 1);
    step(1);
    chk("R4 urgent at cap", rf_urgent, 1);
    step(REFI);
    banks_idle = 1'b1;
    step(TRP);
    for (int p = 0; p < MAXD - 1; p++) begin
      issue();
      step(TRFC);
    end
    chk("R4 req after cap-1 issues", rf_req, 1);
    chk("R4 urgent drops below cap", rf_urgent, 0);
    issue();
    step(TRFC);
    chk("R4 saturated debt cleared", rf_req, 0);

    // Scenario C: gap ceiling with refreshes pulled in
    do_reset();
    banks_idle = 1'b1;
    step(TRP);
    issue(); step(TRFC);
    issue(); step(TRFC);
    issue();
    step(GAP - LEAD - 1);
    chk("R5 urgent one edge early", rf_urgent, 0);
    step(1);
    chk("R5 urgent at gap limit", rf_urgent, 1);
    chk("R5 req at gap limit", rf_req, 1);

    // Scenario D: self-refresh entry and exit
    do_reset();
    banks_idle = 1'b1;
    step(REFI);
    sr_req = 1'b1;
    step(5);
    chk("R9 no entry while owed", cke, 1);
    issue();
    step(TRFC - 1);
    chk("R9 no entry in recovery", cke, 1);
    step(1);
    chk("R9 entry not yet taken", cke, 1);
    step(1);
    chk("R9 cke low in self-refresh", cke, 0);
    chk("R9 cmd_ready low", cmd_ready, 0);
    chk("R9 rf_allow low", rf_allow, 0);
    step(1000);
    chk("R11 no req in self-refresh", rf_req, 0);
    chk("R11 no urgent in self-refresh", rf_urgent, 0);
    sr_req = 1'b0;
    step(1);
    chk("R10 cke back high", cke, 1);
    chk("R10 cmd_ready blocked", cmd_ready, 0);
    step(XSNR - 1);
    chk("R10 cmd_ready one edge early", cmd_ready, 0);
    step(1);
    chk("R10 cmd_ready after exit delay", cmd_ready, 1);
    chk("R10 rd_ready still blocked", rd_ready, 0);
    step(XSRD - 1 - XSNR);
    chk("R10 rd_ready one edge early", rd_ready, 0);
    step(1);
    chk("R10 rd_ready after read delay", rd_ready, 1);
    chk("R11 debt cleared on exit", rf_req, 0);
    step(REFI - 1);
    chk("R11 req one edge early after exit", rf_req, 0);
    step(1);
    chk("R11 req one period after exit", rf_req, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule